// File: doc/BRIEF.md
# Power-Mode Sequencer

This block is the power-mode state machine of a small microcontroller. It keeps track of six operating modes: full run, reduced-regulator run, wait, reduced-regulator wait, a shallow stop and a deep stop. Software requests a new mode with a one-cycle strobe and a 3-bit mode code. The sequencer accepts a request only if the transition is on its permitted graph. A refused request leaves the mode as it is and raises a sticky error bit. From the current mode the sequencer derives the CPU clock enable, the bus clock enable and the regulator active/standby control.

Peripheral interrupt lines wake the sequencer from the sleeping modes. The wait modes resume at once. The shallow stop goes through a timed recovery: a programmable regulator settle count, then 16 reference-clock ticks, then 11 bus cycles, and only then is the interrupt taken. Waking from the deep stop does not resume execution. It reboots the system with a reset pulse and comes up in full run.

Top module: `lpm_ctrl`

## Requirements
- R1: After `rst_n` is released, `mode_o` is 0 (full run), all three clock/regulator controls are 1, and `sys_rst`, `err_flag` and `irq_take` are 0.
- R2: Mode codes are 0 run, 1 reduced run, 2 wait, 3 reduced wait, 4 shallow stop, 5 deep stop. Each mode drives its outputs as follows:
  - run: CPU 1, bus 1, regulator 1.
  - reduced run: CPU 1, bus 1, regulator 0.
  - wait: CPU 0, bus 1, regulator 1.
  - reduced wait: CPU 0, bus 1, regulator 0.
  - either stop: all three 0.
- R3: From run, a request for codes 1, 2, 4 or 5 is accepted on the next cycle. A request for code 3, 6 or 7 is refused. A request for code 0 changes nothing.
- R4: From reduced run, a request for codes 0, 3 or 4 is accepted. A request for code 2, 5, 6 or 7 is refused. A request for code 1 changes nothing.
- R5: A request from run for reduced run is accepted only while `clk_lp_ext` is 1. Otherwise it is refused.
- R6: While `lvd_on` is 1, a request from run for the deep stop enters the shallow stop instead.
- R7: A refused request leaves `mode_o` unchanged and sets `err_flag`. `err_flag` stays set until `err_clr` is pulsed, and a new refusal in the same cycle wins over the clear.
- R8: In wait or reduced wait, any bit of `wake_irq` returns the block on the next cycle with `irq_take` high for exactly one cycle.
  - Wait returns to run.
  - Reduced wait returns to reduced run if `lpw_to_lprun` is 1, and to run otherwise.
- R9: Every bit of `wake_irq` wakes the shallow stop. The bits are 0 ADC, 1 comparator, 2 external IRQ pin, 3 keyboard, 4 low-voltage, 5 periodic timer, 6 serial. The shallow stop returns to the run mode it was entered from.
- R10: A shallow-stop wake goes through three phases while `mode_o` stays 4. The interrupt is then taken: the target mode appears with `irq_take` high for one cycle.
  - Settle: regulator 1 and clocks 0, for `SETTLE_CYC` cycles.
  - Reference wait: the same outputs, until 16 `ref_tick` pulses have been counted.
  - Bus count: CPU, bus and regulator all 1, for 11 cycles.
- R11: Only `wake_irq` bits 2 or 5 wake the deep stop. The wake holds `sys_rst` high for `RST_CYC` cycles, with mode 5, regulator 1 and clocks 0. The block then comes up in run with `err_flag` cleared.
- R12: Requests made outside run and reduced run are ignored and never set `err_flag`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Mode request strobe |
| req_mode | input | 3 | Requested mode code |
| lpw_to_lprun | input | 1 | Reduced-wait wake target select |
| lvd_on | input | 1 | Low-voltage detector enabled |
| clk_lp_ext | input | 1 | Clock subsystem is in bypassed-external low-power mode |
| ref_tick | input | 1 | One pulse per reference-clock cycle |
| wake_irq | input | 7 | Enabled interrupt lines |
| err_clr | input | 1 | Clears the sticky error bit |
| mode_o | output | 3 | Current mode code |
| cpu_clk_en | output | 1 | CPU clock enable |
| bus_clk_en | output | 1 | Bus/peripheral clock enable |
| vreg_active | output | 1 | Regulator active (1) or standby (0) |
| sys_rst | output | 1 | System reset after a deep-stop wake |
| err_flag | output | 1 | Sticky refused-request flag |
| irq_take | output | 1 | Wake interrupt taken |

## Verification
The assertions assume that `wake_irq`, `lvd_on` and `clk_lp_ext` are synchronous to `clk`. They also assume that `err_clr` is a level that software drives only while it wants the flag cleared. The stimulus changes every input on the falling edge only and pulses wake lines for a single cycle. It holds `ref_tick` high except during a deliberate stall of the reference count. It issues requests only as one-cycle strobes, so every property sees one decision per edge.

// File: rtl/lpm_ctrl.sv
`timescale 1ns/1ps
module lpm_ctrl #(
  parameter int SETTLE_CYC = 80,
  parameter int REF_CYC    = 16,
  parameter int BUS_CYC    = 11,
  parameter int RST_CYC    = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_valid,
  input  logic [2:0] req_mode,
  input  logic       lpw_to_lprun,
  input  logic       lvd_on,
  input  logic       clk_lp_ext,
  input  logic       ref_tick,
  input  logic [6:0] wake_irq,
  input  logic       err_clr,
  output logic [2:0] mode_o,
  output logic       cpu_clk_en,
  output logic       bus_clk_en,
  output logic       vreg_active,
  output logic       sys_rst,
  output logic       err_flag,
  output logic       irq_take
);
  localparam int M1   = (SETTLE_CYC > REF_CYC) ? SETTLE_CYC : REF_CYC;
  localparam int M2   = (BUS_CYC > RST_CYC) ? BUS_CYC : RST_CYC;
  localparam int MAXC = (M1 > M2) ? M1 : M2;
  localparam int CW   = $clog2(MAXC + 1);

  localparam logic [2:0] M_RUN = 3'd0, M_LPRUN = 3'd1, M_WAIT = 3'd2,
                         M_LPWAIT = 3'd3, M_STOP_SH = 3'd4, M_STOP_DEEP = 3'd5;

  typedef enum logic [3:0] {
    ST_RUN, ST_LPRUN, ST_WAIT, ST_LPWAIT, ST_STOP_SH, ST_STOP_DEEP,
    ST_SETTLE, ST_REF, ST_BUS, ST_REBOOT
  } st_t;

  st_t           st, nst;
  logic [CW-1:0] cnt, ncnt;
  logic          back_lp, nback, nerr, nirq;

  wire any_wake  = |wake_irq;
  wire deep_wake = wake_irq[2] | wake_irq[5];
  wire cnt_done  = (cnt == '0);

  always_comb begin
    logic from_lp, refuse;
    nst     = st;
    ncnt    = cnt;
    nback   = back_lp;
    nerr    = err_flag & ~err_clr;
    nirq    = 1'b0;
    from_lp = (st == ST_LPRUN);
    refuse  = 1'b0;
    case (st)
      ST_RUN, ST_LPRUN: if (req_valid) begin
        case (req_mode)
          M_RUN:      if (from_lp) nst = ST_RUN;
          M_LPRUN:    if (!from_lp) begin
                        if (clk_lp_ext) nst = ST_LPRUN;
                        else refuse = 1'b1;
                      end
          M_WAIT:     if (from_lp) refuse = 1'b1;
                      else nst = ST_WAIT;
          M_LPWAIT:   if (from_lp) nst = ST_LPWAIT;
                      else refuse = 1'b1;
          M_STOP_SH:  begin nst = ST_STOP_SH; nback = from_lp; end
          M_STOP_DEEP: if (from_lp) refuse = 1'b1;
                       else if (lvd_on) begin nst = ST_STOP_SH; nback = 1'b0; end
                       else nst = ST_STOP_DEEP;
          default:    refuse = 1'b1;
        endcase
        if (refuse) nerr = 1'b1;
      end
      ST_WAIT: if (any_wake) begin nst = ST_RUN; nirq = 1'b1; end
      ST_LPWAIT: if (any_wake) begin
        nst  = lpw_to_lprun ? ST_LPRUN : ST_RUN;
        nirq = 1'b1;
      end
      ST_STOP_SH: if (any_wake) begin
        nst  = ST_SETTLE;
        ncnt = CW'(SETTLE_CYC - 1);
      end
      ST_SETTLE:
        if (cnt_done) begin nst = ST_REF; ncnt = CW'(REF_CYC - 1); end
        else ncnt = cnt - 1'b1;
      ST_REF: if (ref_tick) begin
        if (cnt_done) begin nst = ST_BUS; ncnt = CW'(BUS_CYC - 1); end
        else ncnt = cnt - 1'b1;
      end
      ST_BUS:
        if (cnt_done) begin
          nst  = back_lp ? ST_LPRUN : ST_RUN;
          nirq = 1'b1;
        end else ncnt = cnt - 1'b1;
      ST_STOP_DEEP: if (deep_wake) begin
        nst  = ST_REBOOT;
        ncnt = CW'(RST_CYC - 1);
        nerr = 1'b0;
      end
      ST_REBOOT: begin
        nerr = 1'b0;
        if (cnt_done) nst = ST_RUN;
        else ncnt = cnt - 1'b1;
      end
      default: nst = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st       <= ST_RUN;
      cnt      <= '0;
      back_lp  <= 1'b0;
      err_flag <= 1'b0;
      irq_take <= 1'b0;
    end else begin
      st       <= nst;
      cnt      <= ncnt;
      back_lp  <= nback;
      err_flag <= nerr;
      irq_take <= nirq;
    end

  always_comb begin
    mode_o  = M_RUN;
    sys_rst = 1'b0;
    {cpu_clk_en, bus_clk_en, vreg_active} = 3'b111;
    case (st)
      ST_LPRUN:     begin mode_o = M_LPRUN;     {cpu_clk_en, bus_clk_en, vreg_active} = 3'b110; end
      ST_WAIT:      begin mode_o = M_WAIT;      {cpu_clk_en, bus_clk_en, vreg_active} = 3'b011; end
      ST_LPWAIT:    begin mode_o = M_LPWAIT;    {cpu_clk_en, bus_clk_en, vreg_active} = 3'b010; end
      ST_STOP_SH:   begin mode_o = M_STOP_SH;   {cpu_clk_en, bus_clk_en, vreg_active} = 3'b000; end
      ST_STOP_DEEP: begin mode_o = M_STOP_DEEP; {cpu_clk_en, bus_clk_en, vreg_active} = 3'b000; end
      ST_SETTLE, ST_REF: begin mode_o = M_STOP_SH; {cpu_clk_en, bus_clk_en, vreg_active} = 3'b001; end
      ST_BUS:       begin mode_o = M_STOP_SH;   {cpu_clk_en, bus_clk_en, vreg_active} = 3'b111; end
      ST_REBOOT:    begin mode_o = M_STOP_DEEP; {cpu_clk_en, bus_clk_en, vreg_active} = 3'b001; sys_rst = 1'b1; end
      default: ;
    endcase
  end
endmodule

// File: rtl/lpm_ctrl_chk.sv
`timescale 1ns/1ps
module lpm_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       clk_lp_ext,
  input logic       lvd_on,
  input logic       err_clr,
  input logic [6:0] wake_irq,
  input logic [2:0] mode_o,
  input logic       cpu_clk_en,
  input logic       bus_clk_en,
  input logic       vreg_active,
  input logic       sys_rst,
  input logic       err_flag
);
  localparam logic [2:0] M_RUN = 3'd0, M_LPRUN = 3'd1, M_WAIT = 3'd2,
                         M_LPWAIT = 3'd3, M_STOP_DEEP = 3'd5;
  localparam logic [6:0] DEEP_MASK = 7'b0100100;

  assert_wait_clocks_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == M_WAIT || mode_o == M_LPWAIT) |-> (!cpu_clk_en && bus_clk_en));

  assert_lp_standby_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == M_LPRUN || mode_o == M_LPWAIT) |-> !vreg_active);

  assert_lpwait_path_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o != M_LPRUN && mode_o != M_LPWAIT) |=> mode_o != M_LPWAIT);

  assert_lprun_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == M_RUN && !clk_lp_ext) |=> mode_o != M_LPRUN);

  assert_deep_demote_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == M_RUN && lvd_on) |=> mode_o != M_STOP_DEEP);

  assert_err_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (err_flag && !err_clr && mode_o != M_STOP_DEEP) |=> err_flag);

  assert_deep_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == M_STOP_DEEP && !sys_rst && (wake_irq & DEEP_MASK) == 7'd0) |=> mode_o == M_STOP_DEEP);

  assert_reboot_clocks_R11: assert property (@(posedge clk) disable iff (!rst_n)
    sys_rst |-> (!cpu_clk_en && !bus_clk_en && vreg_active));
endmodule

bind lpm_ctrl lpm_ctrl_chk u_chk (.*);

// File: tb/lpm_ctrl_test.sv
`timescale 1ns/1ps
module lpm_ctrl_test;
  localparam int S = 6;
  localparam int R = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, lpw_to_lprun = 1'b0, lvd_on = 1'b0, clk_lp_ext = 1'b0;
  logic ref_tick = 1'b1, err_clr = 1'b0;
  logic [2:0] req_mode = 3'd0;
  logic [6:0] wake_irq = 7'd0;
  logic [2:0] mode_o;
  logic cpu_clk_en, bus_clk_en, vreg_active, sys_rst, err_flag, irq_take;

  lpm_ctrl #(.SETTLE_CYC(S), .REF_CYC(16), .BUS_CYC(11), .RST_CYC(R)) uut (.*);

  always #5 clk = ~clk;

  int cyc = 0, n_cmp = 0, n_bad = 0;
  bit done = 1'b0;
  logic e_err = 1'b0;
  int q_cyc[$];
  logic [8:0] q_val[$];
  string q_tag[$];
  logic [8:0] got;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [8:0] vec(input logic [2:0] m, input logic [2:0] cbv,
                                     input logic rst, input logic er, input logic irq);
    return {m, cbv, rst, er, irq};
  endfunction

  function automatic logic [8:0] mv(input logic [2:0] m, input logic er, input logic irq);
    logic [2:0] cbv;
    case (m)
      3'd0: cbv = 3'b111;
      3'd1: cbv = 3'b110;
      3'd2: cbv = 3'b011;
      3'd3: cbv = 3'b010;
      default: cbv = 3'b000;
    endcase
    return vec(m, cbv, 1'b0, er, irq);
  endfunction

  task automatic expect_at(input int ahead, input logic [8:0] v, input string tag);
    q_cyc.push_back(cyc + ahead);
    q_val.push_back(v);
    q_tag.push_back(tag);
  endtask

  always @(negedge clk) begin
    while (q_cyc.size() > 0 && q_cyc[0] <= cyc) begin
      got = {mode_o, cpu_clk_en, bus_clk_en, vreg_active, sys_rst, err_flag, irq_take};
      n_cmp++;
      if (q_cyc[0] != cyc || got !== q_val[0]) begin
        n_bad++;
        $display("FAIL %s cyc %0d got %b expected %b", q_tag[0], cyc, got, q_val[0]);
      end
      void'(q_cyc.pop_front());
      void'(q_val.pop_front());
      void'(q_tag.pop_front());
    end
  end

  task automatic req(input logic [2:0] code, input logic [2:0] exp_m, input logic refused, input string tag);
    @(negedge clk);
    req_valid = 1'b1;
    req_mode  = code;
    if (refused) e_err = 1'b1;
    expect_at(1, mv(exp_m, e_err, 1'b0), tag);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic clr();
    @(negedge clk);
    err_clr = 1'b1;
    e_err   = 1'b0;
    expect_at(1, mv(3'd0, 1'b0, 1'b0), "R7 clear");
    @(negedge clk);
    err_clr = 1'b0;
  endtask

  task automatic clr_in(input logic [2:0] m);
    @(negedge clk);
    err_clr = 1'b1;
    e_err   = 1'b0;
    expect_at(1, mv(m, 1'b0, 1'b0), "R7 clear");
    @(negedge clk);
    err_clr = 1'b0;
  endtask

  task automatic wake_fast(input int line, input logic sel, input logic [2:0] tgt, input string tag);
    @(negedge clk);
    wake_irq[line] = 1'b1;
    lpw_to_lprun = sel;
    expect_at(1, mv(tgt, e_err, 1'b1), tag);
    expect_at(2, mv(tgt, e_err, 1'b0), tag);
    @(negedge clk);
    wake_irq = 7'd0;
    @(negedge clk);
  endtask

  task automatic wake_shallow(input int line, input int g, input logic [2:0] tgt, input string tag);
    int rlen;
    rlen = 15 + g;
    @(negedge clk);
    wake_irq[line] = 1'b1;
    ref_tick = 1'b0;
    for (int i = 1; i <= S; i++) expect_at(i, vec(3'd4, 3'b001, 1'b0, e_err, 1'b0), {tag, " settle"});
    for (int i = 1; i <= rlen; i++) expect_at(S + i, vec(3'd4, 3'b001, 1'b0, e_err, 1'b0), {tag, " ref"});
    for (int i = 1; i <= 11; i++) expect_at(S + rlen + i, vec(3'd4, 3'b111, 1'b0, e_err, 1'b0), {tag, " bus"});
    expect_at(S + rlen + 12, mv(tgt, e_err, 1'b1), {tag, " taken"});
    expect_at(S + rlen + 13, mv(tgt, e_err, 1'b0), {tag, " after"});
    @(negedge clk);
    wake_irq = 7'd0;
    repeat (S + g - 1) @(negedge clk);
    ref_tick = 1'b1;
    repeat (rlen + 13 - g) @(negedge clk);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    expect_at(1, mv(3'd0, 1'b0, 1'b0), "R1 reset state");
    @(negedge clk);

    req(3'd3, 3'd0, 1'b1, "R3 run->lpwait refused");
    clr();
    req(3'd6, 3'd0, 1'b1, "R3 code 6 refused");
    clr();
    req(3'd0, 3'd0, 1'b0, "R3 run->run no change");
    req(3'd1, 3'd0, 1'b1, "R5 lprun without lp clock");
    clr();
    clk_lp_ext = 1'b1;
    req(3'd1, 3'd1, 1'b0, "R5 lprun accepted");
    req(3'd5, 3'd1, 1'b1, "R4 lprun->deep refused");
    req(3'd2, 3'd1, 1'b1, "R4 lprun->wait refused");
    clr_in(3'd1);
    req(3'd3, 3'd3, 1'b0, "R4 lprun->lpwait R2 outputs");
    wake_fast(3, 1'b1, 3'd1, "R8 lpwait wake to lprun");
    req(3'd3, 3'd3, 1'b0, "R4 lpwait again");
    wake_fast(0, 1'b0, 3'd0, "R8 lpwait wake to run");

    req(3'd2, 3'd2, 1'b0, "R3 run->wait R2 outputs");
    req(3'd7, 3'd2, 1'b0, "R12 request ignored in wait");
    wake_fast(6, 1'b0, 3'd0, "R8 wait wake");

    req(3'd4, 3'd4, 1'b0, "R3 run->shallow stop R2");
    wake_shallow(0, 1, 3'd0, "R10 R9 stop wake to run");
    req(3'd1, 3'd1, 1'b0, "R5 lprun again");
    req(3'd4, 3'd4, 1'b0, "R4 lprun->shallow stop");
    wake_shallow(4, 5, 3'd1, "R9 stop back to lprun with ref stall R10");
    req(3'd0, 3'd0, 1'b0, "R4 lprun->run");

    lvd_on = 1'b1;
    req(3'd5, 3'd4, 1'b0, "R6 deep demoted");
    wake_shallow(1, 1, 3'd0, "R6 demoted stop wake");
    lvd_on = 1'b0;

    req(3'd6, 3'd0, 1'b1, "R7 error before deep stop");
    req(3'd5, 3'd5, 1'b0, "R3 run->deep stop");
    @(negedge clk);
    wake_irq[3] = 1'b1;
    expect_at(1, mv(3'd5, e_err, 1'b0), "R11 keyboard ignored");
    @(negedge clk);
    wake_irq = 7'd0;
    @(negedge clk);
    wake_irq[5] = 1'b1;
    e_err = 1'b0;
    for (int i = 1; i <= R; i++) expect_at(i, vec(3'd5, 3'b001, 1'b1, 1'b0, 1'b0), "R11 reboot pulse");
    expect_at(R + 1, mv(3'd0, 1'b0, 1'b0), "R11 up in run");
    @(negedge clk);
    wake_irq = 7'd0;
    repeat (R + 2) @(negedge clk);

    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule